// File: doc/BRIEF.md
# USB IN Endpoint Transmit Engine

This block answers host IN tokens for a small bank of device endpoints. Each endpoint carries a 2-bit transmit status, a data-toggle bit and a completion flag. When a token reaches an endpoint whose status is VALID, the engine fetches that endpoint's buffer descriptor, which holds a start word address and a byte count. It then reads 16-bit words from packet memory and hands a byte stream to a downstream bit serializer over a valid/ready link. The stream is a data PID, the payload and a CRC16. An endpoint in NAK or STALL status instead gets a single handshake PID. An endpoint in disabled status gets no reply at all.

After a data packet the engine waits for the host's verdict. An ACK does three things in one clock: it flips the toggle, drops the endpoint to NAK and raises the completion flag. The endpoint then NAKs further tokens until software rearms it, which gives flow control in hardware. A timeout leaves everything as it was, so a retried token resends identical data. Software sees the per-endpoint state through a small read/write register port, and an interrupt output reports which endpoint finished.

Top module: `in_xmit_engine`

## Requirements
- R1: A token to a VALID (2'b11) endpoint causes exactly one descriptor read for that endpoint. The descriptor word carries the start word address in bits [31:16] and the byte count in bits [15:0]. The resulting packet is PID, payload and two CRC bytes, and `tx_last` is set only on the final CRC byte.
- R2: The first byte of a data packet is 8'hC3 when the endpoint toggle is 0 and 8'h4B when it is 1.
- R3: Payload byte k comes from the packet word at start address + k/2, taking the low byte for even k and the high byte for odd k. The engine reads ceil(count/2) words, and for an odd count the high byte of the last word is never sent.
- R4: The two bytes after the payload are the bitwise inverse of a CRC16 (polynomial x^16+x^15+x^2+1, register preset to all ones, data taken least significant bit first), low byte first. A zero count yields the PID followed directly by 8'h00, 8'h00.
- R5: A token to an endpoint in NAK (2'b10) status yields the single byte 8'h5A, and one in STALL (2'b01) status yields 8'h1E. In both cases `tx_last` is set and neither the descriptor nor packet memory is read.
- R6: A token to a disabled (2'b00) endpoint produces no output byte.
- R7: A `host_ack` pulse while awaiting the verdict flips that endpoint's toggle, sets its status to NAK and sets its completion flag, all in one clock. The next token to that endpoint is NAKed.
- R8: A `hs_timeout` pulse while awaiting the verdict leaves toggle, status and flag unchanged. A retried token resends the same PID and the same bytes.
- R9: `irq` is high while any completion flag is set. `irq_ep` gives the lowest-numbered flagged endpoint, and `irq_dir` reads 1 to mark the transmit direction.
- R10: A register write uses these fields of `sw_wr_data`: [1:0] status, [2] toggle, [3] flag, [4] status enable, [5] toggle enable. Status is loaded only when bit 4 is 1 and the toggle only when bit 5 is 1. Bit 3 at 0 clears the flag and at 1 leaves it. `sw_rd_data` reads {flag, toggle, status[1:0]} of `sw_rd_ep`.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R12: Tokens that arrive while a packet is being sent or a verdict is awaited are dropped and cause no later packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | One-cycle IN token strobe |
| tok_ep | input | EPW | Endpoint addressed by the token |
| desc_rd_en | output | 1 | Descriptor memory read strobe |
| desc_rd_ep | output | EPW | Descriptor entry index |
| desc_rd_data | input | 32 | Descriptor word, valid one cycle after the strobe |
| pm_rd_en | output | 1 | Packet memory read strobe |
| pm_rd_addr | output | 16 | Packet memory word address |
| pm_rd_data | input | 16 | Packet word, valid one cycle after the strobe |
| tx_valid | output | 1 | Byte available to the serializer |
| tx_data | output | 8 | Byte to send |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Serializer accepts the byte |
| host_ack | input | 1 | Host ACK seen for the last data packet |
| hs_timeout | input | 1 | Handshake wait expired |
| sw_wr_en | input | 1 | Register write strobe |
| sw_wr_ep | input | EPW | Endpoint written |
| sw_wr_data | input | 6 | Write fields, see R10 |
| sw_rd_ep | input | EPW | Endpoint read |
| sw_rd_data | output | 4 | {flag, toggle, status} |
| irq | output | 1 | Any completion flag set |
| irq_ep | output | EPW | Lowest flagged endpoint |
| irq_dir | output | 1 | Direction of the completion (1 = transmit) |

## Verification
The assertions assume both memories answer exactly one cycle after their read strobe, and that `host_ack` and `hs_timeout` never pulse in the same cycle. They also assume a software write never lands on the endpoint that an ACK updates in that same cycle. The bench models both memories with a single registered stage. It issues the verdict pulses one at a time and only after the last CRC byte has gone out, and it makes every register write while the engine is idle or the target endpoint is not in flight. Backpressure is applied in a fixed pattern on one packet so that the hold property is exercised.

// File: rtl/in_xmit_pkg.sv
package in_xmit_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_STALL = 2'b01,
        ST_NAK   = 2'b10,
        ST_VALID = 2'b11
    } ep_stat_e;

    localparam logic [7:0] PID_DATA0 = 8'hC3;
    localparam logic [7:0] PID_DATA1 = 8'h4B;
    localparam logic [7:0] PID_NAK   = 8'h5A;
    localparam logic [7:0] PID_STALL = 8'h1E;

    // per-endpoint software-visible state
    typedef struct packed {
        logic     flag;
        logic     tog;
        ep_stat_e stat;
    } ep_state_t;

    // descriptor entry as delivered by the descriptor memory
    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] count;
    } bd_entry_t;

    typedef enum logic [3:0] {
        S_IDLE, S_HSK, S_BDREQ, S_BDCAP, S_PID, S_FETCH,
        S_LATCH, S_LO, S_HI, S_CRC_L, S_CRC_H, S_WACK
    } seq_e;

    // reflected CRC16 update for one byte, LSB first
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/in_xmit_crc.sv
module in_xmit_crc
    import in_xmit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [15:0]       crc_q
);
    always_ff @(posedge clk) begin
        if (rst || clear) crc_q <= 16'hFFFF;
        else if (en)      crc_q <= crc16_byte(crc_q, din);
    end
endmodule

// File: rtl/in_xmit_epbank.sv
module in_xmit_epbank
    import in_xmit_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPW    = 2
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [EPW-1:0]         wr_ep,
    input  logic [5:0]             wr_data,
    input  logic [EPW-1:0]         rd_ep,
    output logic [3:0]             rd_data,
    input  logic                   ack_fire,
    input  logic [EPW-1:0]         ack_ep,
    output ep_state_t [NUM_EP-1:0] ep_q,
    output logic                   irq,
    output logic [EPW-1:0]         irq_ep
);
    ep_state_t st_r [NUM_EP];

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic hit_ack, hit_wr;
        assign hit_ack = ack_fire && (ack_ep == EPW'(i));
        assign hit_wr  = wr_en && (wr_ep == EPW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                st_r[i] <= '0;
            end else if (hit_ack) begin
                st_r[i].tog  <= ~st_r[i].tog;
                st_r[i].stat <= ST_NAK;
                st_r[i].flag <= 1'b1;
            end else if (hit_wr) begin
                if (wr_data[4]) st_r[i].stat <= ep_stat_e'(wr_data[1:0]);
                if (wr_data[5]) st_r[i].tog  <= wr_data[2];
                if (!wr_data[3]) st_r[i].flag <= 1'b0;
            end
        end

        // R7: ACK flips toggle, forces NAK and flags completion together
        p_ack_update_r7: assert property (@(posedge clk) disable iff (rst)
            hit_ack |=> (st_r[i].stat == ST_NAK) && st_r[i].flag && (st_r[i].tog != $past(st_r[i].tog)));

        // R10: a write without enables only touches the flag
        p_flag_only_r10: assert property (@(posedge clk) disable iff (rst)
            (hit_wr && !hit_ack && !wr_data[4] && !wr_data[5])
            |=> $stable(st_r[i].stat) && $stable(st_r[i].tog));

        assign ep_q[i] = st_r[i];
    end

    assign rd_data = st_r[rd_ep];

    always_comb begin
        irq    = 1'b0;
        irq_ep = '0;
        for (int i = NUM_EP - 1; i >= 0; i--) begin
            if (st_r[i].flag) begin
                irq    = 1'b1;
                irq_ep = EPW'(i);
            end
        end
    end
endmodule

// File: rtl/in_xmit_seq.sv
module in_xmit_seq
    import in_xmit_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPW    = 2
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tok_valid,
    input  logic [EPW-1:0]         tok_ep,
    input  ep_state_t [NUM_EP-1:0] ep_q,
    output logic                   desc_rd_en,
    output logic [EPW-1:0]         desc_rd_ep,
    input  logic [2*WORD_W-1:0]    desc_rd_data,
    output logic                   pm_rd_en,
    output logic [WORD_W-1:0]      pm_rd_addr,
    input  logic [WORD_W-1:0]      pm_rd_data,
    output logic                   tx_valid,
    output logic [BYTE_W-1:0]      tx_data,
    output logic                   tx_last,
    input  logic                   tx_ready,
    input  logic                   host_ack,
    input  logic                   hs_timeout,
    input  logic [15:0]            crc_q,
    output logic                   crc_clear,
    output logic                   crc_en,
    output logic                   ack_fire,
    output logic [EPW-1:0]         ack_ep
);
    seq_e              st;
    logic [EPW-1:0]    cur_ep;
    logic              cur_tog;
    logic [7:0]        hs_pid;
    logic [WORD_W-1:0] ptr;
    logic [WORD_W-1:0] cnt;
    logic [WORD_W-1:0] word;
    bd_entry_t         bd;
    ep_state_t         tok_st;

    assign bd     = bd_entry_t'(desc_rd_data);
    assign tok_st = ep_q[tok_ep];
    logic take;
    assign take   = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cur_ep  <= '0;
            cur_tog <= 1'b0;
            hs_pid  <= '0;
            ptr     <= '0;
            cnt     <= '0;
            word    <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (tok_valid) begin
                    cur_ep  <= tok_ep;
                    cur_tog <= tok_st.tog;
                    unique case (tok_st.stat)
                        ST_VALID: st <= S_BDREQ;
                        ST_NAK:   begin hs_pid <= PID_NAK;   st <= S_HSK; end
                        ST_STALL: begin hs_pid <= PID_STALL; st <= S_HSK; end
                        default:  st <= S_IDLE;
                    endcase
                end
                S_HSK:   if (take) st <= S_IDLE;
                S_BDREQ: st <= S_BDCAP;
                S_BDCAP: begin
                    ptr <= bd.addr;
                    cnt <= bd.count;
                    st  <= S_PID;
                end
                S_PID:   if (take) st <= (cnt == '0) ? S_CRC_L : S_FETCH;
                S_FETCH: st <= S_LATCH;
                S_LATCH: begin
                    word <= pm_rd_data;
                    ptr  <= ptr + 1'b1;
                    st   <= S_LO;
                end
                S_LO: if (take) begin
                    cnt <= cnt - 1'b1;
                    st  <= (cnt == 16'd1) ? S_CRC_L : S_HI;
                end
                S_HI: if (take) begin
                    cnt <= cnt - 1'b1;
                    st  <= (cnt == 16'd1) ? S_CRC_L : S_FETCH;
                end
                S_CRC_L: if (take) st <= S_CRC_H;
                S_CRC_H: if (take) st <= S_WACK;
                S_WACK:  if (host_ack || hs_timeout) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            S_HSK:   tx_data = hs_pid;
            S_PID:   tx_data = cur_tog ? PID_DATA1 : PID_DATA0;
            S_LO:    tx_data = word[7:0];
            S_HI:    tx_data = word[15:8];
            S_CRC_L: tx_data = ~crc_q[7:0];
            S_CRC_H: tx_data = ~crc_q[15:8];
            default: tx_data = '0;
        endcase
    end

    assign tx_valid   = (st == S_HSK) || (st == S_PID) || (st == S_LO) ||
                        (st == S_HI) || (st == S_CRC_L) || (st == S_CRC_H);
    assign tx_last    = (st == S_HSK) || (st == S_CRC_H);
    assign desc_rd_en = (st == S_BDREQ);
    assign desc_rd_ep = cur_ep;
    assign pm_rd_en   = (st == S_FETCH);
    assign pm_rd_addr = ptr;
    assign crc_clear  = (st == S_BDCAP);
    assign crc_en     = take && ((st == S_LO) || (st == S_HI));
    assign ack_fire   = (st == S_WACK) && host_ack;
    assign ack_ep     = cur_ep;

    // R11: an offered byte is held until taken
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R6: a disabled endpoint leaves the engine idle
    p_off_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && tok_valid && tok_st.stat == ST_OFF) |=> !tx_valid && !desc_rd_en);

    // R5: a handshake is one byte and is followed by silence
    p_hsk_single_r5: assert property (@(posedge clk) disable iff (rst)
        (st == S_HSK && tx_ready) |=> !tx_valid && !desc_rd_en && !pm_rd_en);

    // R3: no word is fetched once the byte count is exhausted
    p_no_overread_r3: assert property (@(posedge clk) disable iff (rst)
        pm_rd_en |-> (cnt != '0));

    // R1: one descriptor read per data packet
    p_one_bdread_r1: assert property (@(posedge clk) disable iff (rst)
        desc_rd_en |=> !desc_rd_en);
endmodule

// File: rtl/in_xmit_engine.sv
module in_xmit_engine
    import in_xmit_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           tok_valid,
    input  logic [EPW-1:0] tok_ep,
    output logic           desc_rd_en,
    output logic [EPW-1:0] desc_rd_ep,
    input  logic [31:0]    desc_rd_data,
    output logic           pm_rd_en,
    output logic [15:0]    pm_rd_addr,
    input  logic [15:0]    pm_rd_data,
    output logic           tx_valid,
    output logic [7:0]     tx_data,
    output logic           tx_last,
    input  logic           tx_ready,
    input  logic           host_ack,
    input  logic           hs_timeout,
    input  logic           sw_wr_en,
    input  logic [EPW-1:0] sw_wr_ep,
    input  logic [5:0]     sw_wr_data,
    input  logic [EPW-1:0] sw_rd_ep,
    output logic [3:0]     sw_rd_data,
    output logic           irq,
    output logic [EPW-1:0] irq_ep,
    output logic           irq_dir
);
    ep_state_t [NUM_EP-1:0] ep_q;
    logic                   ack_fire;
    logic [EPW-1:0]         ack_ep;
    logic [15:0]            crc_q;
    logic                   crc_clear, crc_en;

    in_xmit_epbank #(.NUM_EP(NUM_EP), .EPW(EPW)) bank_i (
        .clk(clk), .rst(rst),
        .wr_en(sw_wr_en), .wr_ep(sw_wr_ep), .wr_data(sw_wr_data),
        .rd_ep(sw_rd_ep), .rd_data(sw_rd_data),
        .ack_fire(ack_fire), .ack_ep(ack_ep),
        .ep_q(ep_q), .irq(irq), .irq_ep(irq_ep)
    );

    in_xmit_seq #(.NUM_EP(NUM_EP), .EPW(EPW)) seq_i (
        .clk(clk), .rst(rst),
        .tok_valid(tok_valid), .tok_ep(tok_ep), .ep_q(ep_q),
        .desc_rd_en(desc_rd_en), .desc_rd_ep(desc_rd_ep), .desc_rd_data(desc_rd_data),
        .pm_rd_en(pm_rd_en), .pm_rd_addr(pm_rd_addr), .pm_rd_data(pm_rd_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .host_ack(host_ack), .hs_timeout(hs_timeout),
        .crc_q(crc_q), .crc_clear(crc_clear), .crc_en(crc_en),
        .ack_fire(ack_fire), .ack_ep(ack_ep)
    );

    in_xmit_crc crc_i (
        .clk(clk), .rst(rst), .clear(crc_clear), .en(crc_en),
        .din(tx_data), .crc_q(crc_q)
    );

    assign irq_dir = 1'b1;
endmodule

// File: tb/in_xmit_engine_tb.sv
module in_xmit_engine_tb_top;
    localparam int NEP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tok_valid = 1'b0;
    logic [1:0]  tok_ep = '0;
    logic        desc_rd_en;
    logic [1:0]  desc_rd_ep;
    logic [31:0] desc_rd_data = '0;
    logic        pm_rd_en;
    logic [15:0] pm_rd_addr;
    logic [15:0] pm_rd_data = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready = 1'b1;
    logic        host_ack = 1'b0;
    logic        hs_timeout = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [1:0]  sw_wr_ep = '0;
    logic [5:0]  sw_wr_data = '0;
    logic [1:0]  sw_rd_ep = '0;
    logic [3:0]  sw_rd_data;
    logic        irq;
    logic [1:0]  irq_ep;
    logic        irq_dir;

    in_xmit_engine #(.NUM_EP(NEP)) dut_i (.*);

    always #10 clk = ~clk;   // 50 MHz

    // memory models, one registered stage each
    logic [15:0] pm [256];
    logic [15:0] bd_addr [NEP];
    logic [15:0] bd_cnt  [NEP];
    always_ff @(posedge clk) begin
        if (desc_rd_en) desc_rd_data <= {bd_addr[desc_rd_ep], bd_cnt[desc_rd_ep]};
        if (pm_rd_en)   pm_rd_data   <= pm[pm_rd_addr[7:0]];
    end

    int vec = 0, bad = 0, cyc = 0;
    bit done = 0;

    // byte collector with optional backpressure
    logic [7:0] rec [128];
    int  rec_n = 0;
    bit  rec_last = 0;
    bit  stall_mode = 0;
    int  n_desc = 0, n_pm = 0, hold_err = 0;
    bit  pv = 0, pr = 1;
    logic [7:0] pd = '0;
    logic pl = 0;

    always @(negedge clk) begin
        if (pv && !pr && !(tx_valid && tx_data == pd && tx_last == pl)) hold_err++;
        tx_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
        if (!rst && tx_valid && tx_ready) begin
            if (rec_n < 128) rec[rec_n] = tx_data;
            rec_n++;
            if (tx_last) rec_last = 1;
        end
        if (!rst && desc_rd_en) n_desc++;
        if (!rst && pm_rd_en) n_pm++;
        pv = tx_valid; pr = tx_ready; pd = tx_data; pl = tx_last;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            bad++; vec++;
            $display("FAIL watchdog: run did not finish (act %0d, exp <100000)", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int b = 0; b < 8; b++) r = (r >> 1) ^ ({16{r[0] ^ d[b]}} & 16'hA001);
        return r;
    endfunction

    task automatic sw_write(input int ep, input logic [5:0] d);
        @(negedge clk); sw_wr_en = 1; sw_wr_ep = 2'(ep); sw_wr_data = d;
        @(negedge clk); sw_wr_en = 0;
    endtask

    task automatic reg_chk(input int ep, input logic [3:0] exp, input string req);
        @(negedge clk); sw_rd_ep = 2'(ep); #1;
        chk(sw_rd_data == exp, req, $sformatf("ep%0d register", ep), sw_rd_data, exp);
    endtask

    task automatic send_token(input int ep);
        rec_n = 0; rec_last = 0;
        @(negedge clk); tok_valid = 1; tok_ep = 2'(ep);
        @(negedge clk); tok_valid = 0;
    endtask

    task automatic wait_pkt();
        for (int i = 0; i < 400 && !rec_last; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk); host_ack = 1; @(negedge clk); host_ack = 0;
    endtask

    task automatic pulse_to();
        @(negedge clk); hs_timeout = 1; @(negedge clk); hs_timeout = 0;
    endtask

    // expected data packet compare (R1..R4)
    task automatic cmp_data(input int ep, input bit tog, input string req);
        logic [7:0] e [128];
        int n = 0;
        logic [15:0] c = 16'hFFFF;
        int errs = 0;
        e[n++] = tog ? 8'h4B : 8'hC3;
        for (int k = 0; k < int'(bd_cnt[ep]); k++) begin
            logic [15:0] w = pm[8'(bd_addr[ep] + 16'(k / 2))];
            logic [7:0] b = (k % 2 == 1) ? w[15:8] : w[7:0];
            e[n++] = b;
            c = crc_ref(c, b);
        end
        e[n++] = ~c[7:0];
        e[n++] = ~c[15:8];
        chk(rec_n == n && rec_last, req, "packet length", rec_n, n);
        for (int k = 0; k < n && k < rec_n; k++)
            if (rec[k] !== e[k]) begin
                errs++;
                $display("FAIL %s byte %0d: actual %0h expected %0h", req, k, rec[k], e[k]);
            end
        vec++;
        if (errs != 0) bad++;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!tx_valid && !irq, "R9", "idle after reset (valid,irq)", {tx_valid, irq}, 0);
        reg_chk(1, 4'b0000, "R10");
    endtask

    task automatic t_data_ack();
        bd_addr[1] = 16'd10; bd_cnt[1] = 16'd6;
        sw_write(1, 6'b011011);
        reg_chk(1, 4'b0011, "R10");
        n_desc = 0; n_pm = 0;
        send_token(1); wait_pkt();
        cmp_data(1, 0, "R1 R2 R3 R4");
        chk(n_desc == 1, "R1", "descriptor reads", n_desc, 1);
        chk(n_pm == 3, "R3", "even-count word reads", n_pm, 3);
        pulse_ack();
        reg_chk(1, 4'b1110, "R7");
        chk(irq && irq_ep == 1 && irq_dir, "R9", "irq/ep/dir", {irq, irq_ep, irq_dir}, 4'b1011);
    endtask

    task automatic t_nak_after_ack();
        n_desc = 0; n_pm = 0;
        send_token(1); wait_pkt();
        chk(rec_n == 1 && rec[0] == 8'h5A && rec_last, "R7 R5", "NAK reply", rec[0], 8'h5A);
        chk(n_desc == 0 && n_pm == 0, "R5", "no memory reads on NAK", n_desc + n_pm, 0);
    endtask

    task automatic t_odd_timeout_retry();
        sw_write(1, 6'b000000);
        reg_chk(1, 4'b0110, "R10");
        chk(!irq, "R9", "irq drops after clear", irq, 0);
        bd_addr[1] = 16'd40; bd_cnt[1] = 16'd5;
        sw_write(1, 6'b011011);
        reg_chk(1, 4'b0111, "R10");
        stall_mode = 1; hold_err = 0; n_pm = 0;
        send_token(1); wait_pkt();
        cmp_data(1, 1, "R2 R3 R4 odd");
        chk(n_pm == 3, "R3", "odd-count word reads", n_pm, 3);
        chk(hold_err == 0, "R11", "hold under backpressure", hold_err, 0);
        stall_mode = 0;
        pulse_to();
        reg_chk(1, 4'b0111, "R8");
        send_token(1); wait_pkt();
        cmp_data(1, 1, "R8 retry");
        pulse_ack();
        reg_chk(1, 4'b1010, "R7");
    endtask

    task automatic t_zero_len();
        bd_addr[2] = 16'd200; bd_cnt[2] = 16'd0;
        sw_write(2, 6'b011011);
        send_token(2); wait_pkt();
        chk(rec_n == 3 && rec[0] == 8'hC3 && rec[1] == 8'h00 && rec[2] == 8'h00,
            "R4", "zero-length packet", {rec[0], rec[1], rec[2]}, 24'hC30000);
        pulse_ack();
        reg_chk(2, 4'b1110, "R7");
        chk(irq && irq_ep == 1, "R9", "priority lowest ep", irq_ep, 1);
        sw_write(1, 6'b000000);
        @(negedge clk);
        chk(irq && irq_ep == 2, "R9", "next flagged ep", irq_ep, 2);
        sw_write(2, 6'b000000);
        @(negedge clk);
        chk(!irq, "R9", "no flags left", irq, 0);
    endtask

    task automatic t_stall();
        sw_write(3, 6'b011001);
        reg_chk(3, 4'b0001, "R10");
        n_desc = 0; n_pm = 0;
        send_token(3); wait_pkt();
        chk(rec_n == 1 && rec[0] == 8'h1E && rec_last, "R5", "STALL reply", rec[0], 8'h1E);
        chk(n_desc == 0 && n_pm == 0, "R5", "no memory reads on STALL", n_desc + n_pm, 0);
    endtask

    task automatic t_disabled();
        sw_write(0, 6'b101100);
        reg_chk(0, 4'b0100, "R10");
        n_desc = 0;
        send_token(0);
        repeat (20) @(negedge clk);
        chk(rec_n == 0 && n_desc == 0, "R6", "disabled endpoint silent", rec_n, 0);
    endtask

    task automatic t_busy_token();
        bd_addr[2] = 16'd100; bd_cnt[2] = 16'd10;
        sw_write(2, 6'b011011);
        reg_chk(2, 4'b0111, "R10");
        send_token(2);
        repeat (4) @(negedge clk);
        tok_valid = 1; tok_ep = 2'd3;
        @(negedge clk); tok_valid = 0;
        wait_pkt();
        cmp_data(2, 1, "R12 packet");
        @(negedge clk); tok_valid = 1; tok_ep = 2'd3;
        @(negedge clk); tok_valid = 0;
        repeat (20) @(negedge clk);
        chk(rec_n == 13, "R12", "no extra reply from dropped tokens", rec_n, 13);
        pulse_to();
        reg_chk(2, 4'b0111, "R8");
        reg_chk(3, 4'b0001, "R12");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) pm[i] = 16'((i * 16'h3B1) ^ 16'h5A3C);
        for (int i = 0; i < NEP; i++) begin bd_addr[i] = '0; bd_cnt[i] = '0; end
        t_reset();
        t_data_ack();
        t_nak_after_ack();
        t_odd_timeout_retry();
        t_zero_len();
        t_stall();
        t_disabled();
        t_busy_token();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule